// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 64 interrupt lines from peripherals into one interrupt request for a single CPU. The lines are split into two banks of 32. Each bank keeps four 32-bit vectors: latched events, an enable mask, the live input levels, and a constant set of sources that are treated as level-triggered. Edge sources latch an event on a rising input and hold it until software clears it. Level sources never latch an event; they request service for as long as their input stays high.

Software reaches both banks through a small 32-bit register port with write and read strobes and one cycle of read latency. Per bank, it can read the events, read and write the mask, clear events and read the levels. Inputs are asynchronous and pass through a synchronizer before they are sampled. The interrupt output is registered.

Top module: `dual_bank_intc`

## Requirements
- R1: Input line n lands in bank 1 − (n / 32) at bit n mod 32. Lines 0 to 31 appear in the bank at offsets 0x20–0x2F, and lines 32 to 63 in the bank at offsets 0x10–0x1F.
- R2: Within a bank the low address nibble picks the register. 0x0 reads events (writes ignored). 0x4 reads and writes the mask. 0x8 is a write-only clear that reads 0. 0xC reads levels (writes ignored). Any other nibble reads 0 and ignores writes.
- R3: Addresses below 0x10, and addresses of 0x30 and above, read 0 and ignore writes.
- R4: For an edge source, a rising edge of the synchronized input sets its event bit. The bit stays set after the input falls, until it is cleared. An input held high does not set the bit again once it has been cleared.
- R5: A write to the clear register clears the event bits set in the written value. Level-triggered sources never have an event bit set, and a clear does not affect them.
- R6: The levels vector follows each synchronized input, high or low, within SYNC_STAGES+1 cycles.
- R7: irq_out is a registered OR over both banks of (events | (levels & level-triggered)) & mask. A mask or clear write accepted at clock edge T changes irq_out at edge T+1 and not before.
- R8: After reset, events, mask and levels are 0 in both banks and irq_out is low. The level-triggered set is 0x00000000 in bank 0 and 0x1FF00000 in bank 1, so lines 20 to 28 are level-triggered.
- R9: Read data for a read strobe sampled at edge T appears on rdata after edge T and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench drives pulses on lines from both halves of the numbering to show that bank selection is reversed. It holds a line high across a clear to tell edge detection apart from level sampling. A level-triggered line is raised under its mask, then given an all-ones clear, to show that clear cannot silence it. It is then released, to show that the request follows the input. Mask and clear writes are timed cycle by cycle against irq_out, and writes to read-only, unused and out-of-range addresses are checked for having no effect on the readable state.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;

  typedef enum logic [3:0] {
    SEL_EVENTS = 4'h0,
    SEL_MASK   = 4'h4,
    SEL_CLEAR  = 4'h8,
    SEL_LEVELS = 4'hC
  } reg_sel_e;

  // Constant level-triggered set per bank
  function automatic logic [BANK_W-1:0] lt_set(input int bank);
    return (bank == 1) ? 32'h1FF0_0000 : '0;
  endfunction
endpackage

// File: rtl/dbic_sync.sv
module dbic_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbic_bank.sv
module dbic_bank #(
  parameter int                BW = 32,
  parameter logic [BW-1:0]     LT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] lvl_in,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] ev_q,
  output logic [BW-1:0] mk_q,
  output logic [BW-1:0] lv_q,
  output logic          pending
);
  logic [BW-1:0] ev_d, mk_d, clr_bits, rise;

  always_comb begin
    clr_bits = clr_we ? (wdata & ~LT) : '0;
    rise     = lvl_in & ~lv_q & ~LT;
    ev_d     = (ev_q & ~clr_bits) | rise;
    mk_d     = mask_we ? wdata : mk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      mk_q <= '0;
      lv_q <= '0;
    end else begin
      ev_q <= ev_d;
      mk_q <= mk_d;
      lv_q <= lvl_in;
    end
  end

  assign pending = |((ev_q | (lv_q & LT)) & mk_q);
endmodule

// File: rtl/dbic_regif.sv
module dbic_regif
  import dbic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NB     = 2,
  parameter int BW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NB-1:0][BW-1:0]  ev,
  input  logic [NB-1:0][BW-1:0]  mk,
  input  logic [NB-1:0][BW-1:0]  lv,
  output logic [NB-1:0]          mask_we,
  output logic [NB-1:0]          clr_we,
  output logic [BW-1:0]          rdata
);
  localparam int IDX_W  = ADDR_W - 4;
  localparam int BSEL_W = (NB > 1) ? $clog2(NB) : 1;

  logic [IDX_W-1:0]  idx;
  logic [BSEL_W-1:0] bsel;
  logic              hit;
  reg_sel_e          sel;
  logic [BW-1:0]     rd_d, rd_q;

  // Bank index: (addr - 0x10) >> 4, wrapping below 0x10
  assign idx  = addr[ADDR_W-1:4] - IDX_W'(1);
  assign bsel = idx[BSEL_W-1:0];
  assign hit  = (idx < IDX_W'(NB));
  assign sel  = reg_sel_e'(addr[3:0]);

  for (genvar b = 0; b < NB; b++) begin : g_strobe
    assign mask_we[b] = wr_en && hit && (idx == IDX_W'(b)) && (sel == SEL_MASK);
    assign clr_we[b]  = wr_en && hit && (idx == IDX_W'(b)) && (sel == SEL_CLEAR);
  end

  always_comb begin
    rd_d = '0;
    if (hit) begin
      case (sel)
        SEL_EVENTS: rd_d = ev[bsel];
        SEL_MASK:   rd_d = mk[bsel];
        SEL_LEVELS: rd_d = lv[bsel];
        default:    rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import dbic_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  output logic                        irq_out
);
  localparam int NL = NUM_BANKS * BANK_W;

  logic [NL-1:0]                     lvl_sync;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  ev, mk, lv;
  logic [NUM_BANKS-1:0]              mask_we, clr_we, pend;
  logic [NL-1:0]                     ev_flat, mk_flat, lv_flat;
  logic                              pend_any, irq_q;

  dbic_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl_sync)
  );

  // Line n goes to bank (NUM_BANKS-1 - n/BANK_W)
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbic_bank #(.BW(BANK_W), .LT(lt_set(b))) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lvl_in(lvl_sync[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .mask_we(mask_we[b]), .clr_we(clr_we[b]), .wdata(wdata),
      .ev_q(ev[b]), .mk_q(mk[b]), .lv_q(lv[b]), .pending(pend[b])
    );
  end

  dbic_regif #(.ADDR_W(ADDR_W), .NB(NUM_BANKS), .BW(BANK_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .ev(ev), .mk(mk), .lv(lv), .mask_we(mask_we), .clr_we(clr_we),
    .rdata(rdata)
  );

  assign pend_any = |pend;
  assign ev_flat  = ev;
  assign mk_flat  = mk;
  assign lv_flat  = lv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/dbic_chk.sv
module dbic_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq_out,
  input logic              pend_any,
  input logic [63:0]       ev_flat,
  input logic [63:0]       mk_flat,
  input logic [63:0]       lv_flat
);
  localparam logic [31:0] LT1 = 32'h1FF0_0000;

  // R7: output is the registered combined request
  a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(pend_any)));

  // R2: a mask write to bank 0 lands in the next cycle
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h014) |=> (mk_flat[31:0] == $past(wdata)));

  // R3: out-of-range reads return zero
  a_r3_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr < 12'h010 || addr >= 12'h030)) |=> (rdata == 32'h0));

  // R4: every new level rise of an edge source shows as an event
  a_r4_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ((lv_flat[31:0] & ~$past(lv_flat[31:0]) & ~ev_flat[31:0]) == 32'h0) &&
    ((lv_flat[63:32] & ~$past(lv_flat[63:32]) & ~LT1 & ~ev_flat[63:32]) == 32'h0));

  // R5: level-triggered sources never hold an event
  a_r5_lt_never_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flat[63:32] & LT1) == 32'h0);

  // R9: mask read of bank 1 returns the value held at the read edge
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 12'h024) |=> (rdata == $past(mk_flat[63:32])));
endmodule

bind dual_bank_intc dbic_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .pend_any(pend_any),
  .ev_flat(ev_flat), .mk_flat(mk_flat), .lv_flat(lv_flat)
);

// File: tb/tb_dual_bank_intc.sv
`timescale 1ns/1ps
module tb_dual_bank_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        irq_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  dual_bank_intc dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R8 irq_out low", {31'h0, irq_out}, 32'h0);
    reg_rd(12'h010, v); check("R8 bank0 events", v, 32'h0);
    reg_rd(12'h024, v); check("R8 bank1 mask", v, 32'h0);
    reg_rd(12'h02C, v); check("R8 bank1 levels", v, 32'h0);
  endtask

  task automatic t_bad_addr;
    logic [31:0] v;
    reg_wr(12'h000, 32'hFFFF_FFFF);
    reg_wr(12'h004, 32'hFFFF_FFFF);
    reg_wr(12'h034, 32'hFFFF_FFFF);
    reg_wr(12'h015, 32'hFFFF_FFFF);
    reg_wr(12'h010, 32'hFFFF_FFFF);
    reg_wr(12'h02C, 32'hFFFF_FFFF);
    reg_rd(12'h014, v); check("R3 bank0 mask untouched", v, 32'h0);
    reg_rd(12'h024, v); check("R3 bank1 mask untouched", v, 32'h0);
    reg_rd(12'h010, v); check("R2 events read-only", v, 32'h0);
    reg_rd(12'h02C, v); check("R2 levels read-only", v, 32'h0);
    reg_rd(12'h034, v); check("R3 read above range", v, 32'h0);
    reg_wr(12'h014, 32'hA5A5_0000);
    reg_rd(12'h004, v); check("R3 read below range", v, 32'h0);
    reg_rd(12'h018, v); check("R2 clear reads zero", v, 32'h0);
    reg_rd(12'h01D, v); check("R2 unused nibble reads zero", v, 32'h0);
    reg_rd(12'h014, v); check("R2 mask readback", v, 32'hA5A5_0000);
    reg_wr(12'h014, 32'h0);
    check("R7 no request with events clear", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_mapping;
    logic [31:0] v;
    irq_in[5] = 1'b1; wait_cyc(6);
    reg_rd(12'h02C, v); check("R1 R6 line5 level in bank1", v, 32'h20);
    reg_rd(12'h01C, v); check("R1 bank0 levels empty", v, 32'h0);
    reg_rd(12'h020, v); check("R1 R4 line5 event in bank1", v, 32'h20);
    irq_in[37] = 1'b1; wait_cyc(6);
    reg_rd(12'h01C, v); check("R1 line37 level in bank0", v, 32'h20);
    irq_in = '0; wait_cyc(6);
    reg_rd(12'h02C, v); check("R6 level falls", v, 32'h0);
    reg_rd(12'h020, v); check("R4 event held after fall", v, 32'h20);
    reg_rd(12'h010, v); check("R4 bank0 event held", v, 32'h20);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    reg_wr(12'h028, 32'h20);
    reg_rd(12'h020, v); check("R5 clear edge event", v, 32'h0);
    reg_wr(12'h018, 32'h20);
    reg_rd(12'h010, v); check("R5 clear bank0 event", v, 32'h0);
    irq_in[3] = 1'b1; wait_cyc(6);
    reg_rd(12'h020, v); check("R4 held line latches", v, 32'h8);
    reg_wr(12'h028, 32'h8); wait_cyc(4);
    reg_rd(12'h020, v); check("R4 held line not re-latched", v, 32'h0);
    irq_in[3] = 1'b0; wait_cyc(6);
  endtask

  task automatic t_level;
    logic [31:0] v;
    irq_in[20] = 1'b1; wait_cyc(6);
    reg_rd(12'h020, v); check("R5 R8 level source no event", v, 32'h0);
    reg_rd(12'h02C, v); check("R6 level source level", v, 32'h0010_0000);
    reg_wr(12'h024, 32'h0010_0000); wait_cyc(2);
    check("R7 level source raises irq", {31'h0, irq_out}, 32'h1);
    reg_wr(12'h028, 32'hFFFF_FFFF); wait_cyc(3);
    check("R5 clear cannot silence level", {31'h0, irq_out}, 32'h1);
    reg_rd(12'h02C, v); check("R5 level bit survives clear", v, 32'h0010_0000);
    irq_in[20] = 1'b0; wait_cyc(6);
    check("R7 irq follows level release", {31'h0, irq_out}, 32'h0);
    reg_wr(12'h024, 32'h0);
  endtask

  task automatic t_mask_timing;
    irq_in[33] = 1'b1; wait_cyc(6);
    irq_in[33] = 1'b0; wait_cyc(4);
    check("R7 masked event no irq", {31'h0, irq_out}, 32'h0);
    @(negedge clk); wr_en = 1'b1; addr = 12'h014; wdata = 32'h2;
    @(negedge clk); wr_en = 1'b0;
    check("R7 irq not yet after mask write", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 irq one cycle after mask write", {31'h0, irq_out}, 32'h1);
    @(negedge clk); wr_en = 1'b1; addr = 12'h018; wdata = 32'h2;
    @(negedge clk); wr_en = 1'b0;
    check("R7 irq held right after clear", {31'h0, irq_out}, 32'h1);
    @(negedge clk);
    check("R7 irq drops after clear", {31'h0, irq_out}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_bad_addr();
    t_mapping();
    t_edge();
    t_level();
    t_mask_timing();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule